// File: doc/BRIEF.md
# Regulator Start-Up and Fault Supervisor

This block sequences the start-up of a multi-output regulator and decides how it reacts to faults. It holds the soft-start level as a digital ramp counter. When the supply check reports power good, the ramp jumps to a low starting step and then climbs at a rate set by a programmable prescaler. The switching stage is enabled once the ramp passes the oscillator valley level. An "up" flag marks the fully charged level. Analog comparators report to the block as synchronous flags: overcurrent, over-voltage and one undervoltage flag for each linear output.

An overcurrent trip inhibits every output and counts one retry. If the ramp is already fully charged, the block discharges it and starts again from the low step. If the trip comes during the charge interval, the outputs stay inhibited while the ramp keeps climbing to the fully charged level; only then does it discharge and restart. The third counted trip sets a fault latch. An over-voltage sets the latch at once and also forces the low-side switch on. Undervoltage on a linear output counts as a trip only after the ramp is fully charged.

A shutdown request drops all outputs and empties the ramp. When shutdown is released, a fresh cycle starts, unless the fault latch is set. Only a power cycle clears the fault latch and the retry count. A power cycle means the power-good input going low.

Top module: `ss_fault_seq`

## Requirements
- R1: While `rst_n` or `por_done` is low: `ss_level` is 0, `inhibit` is 1, and `pwm_en`, `fault` and `low_force` are 0.
- R2: On the first clock edge with `por_done` high, `shutdown` low and no fault, `ss_level` loads the start code 227 (1.0 V of a 4.5 V full scale over 10 bits) and `inhibit` goes low.
- R3: While the ramp runs, `ss_level` rises by one code every `ramp_div`+1 clock edges after the load and saturates at 1023.
- R4: `ss_up` is 1 exactly when `ss_level` is at least 909 (the 4.0 V code).
- R5: `pwm_en` is 1 only while outputs are not inhibited and `ss_level` is above the valley code 272 (1.2 V).
- R6: A trip seen while `ss_up` is 1 gives `inhibit`=1 and `ss_level`=0 on the next edge. The edge after that reloads 227 and releases `inhibit`.
- R7: A trip seen while `ss_up` is 0 sets `inhibit`, and the ramp keeps climbing to 909. It then clears to 0 on the next edge and reloads 227 on the edge after that.
- R8: The third trip since power-up sets `fault`=1, `inhibit`=1 and `ss_level`=0. While `fault` is set, releasing shutdown and any further trips do not restart the ramp.
- R9: `ov_flag` high with `por_done` high gives `fault`=1 and `low_force`=1 on the next edge, whatever the retry count, and both stay set.
- R10: A high bit of `luv_flag` has no effect while `ss_up` is 0. While `ss_up` is 1, it counts as a trip.
- R11: `shutdown` high (with no fault) gives `ss_level`=0 and `inhibit`=1 on the next edge. Releasing it reloads 227 on the next edge.
- R12: Only `por_done` going low clears `fault`, `low_force` and the retry count. After it, three new trips are needed to latch the fault again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_done | input | 1 | Supplies above their power-on thresholds; low means power cycle |
| shutdown | input | 1 | Request to disable all outputs |
| oc_flag | input | 1 | Overcurrent comparator result |
| ov_flag | input | 1 | Core over-voltage comparator result |
| luv_flag | input | N_LIN (3) | Undervoltage flags of the linear outputs |
| ramp_div | input | DIV_W (4) | Prescaler: ramp steps once per ramp_div+1 cycles |
| inhibit | output | 1 | All outputs held off |
| pwm_en | output | 1 | Switching stage allowed to switch |
| low_force | output | 1 | Low-side switch forced on after over-voltage |
| fault | output | 1 | Fault latch |
| ss_level | output | SS_W (10) | Soft-start level code |
| ss_up | output | 1 | Soft-start fully charged |

## Verification
The bench checks the exact edge on which the ramp lands after a load, for several prescaler settings, including saturation at full scale. A wrong prescaler compare would shift these values by one or more codes. It separates a trip during the charge interval from one after full charge. A design that discharged at once on an early trip would show 0 where 909 is expected. It checks that undervoltage is ignored during the charge interval, that the third trip latches the fault, and that the latch survives a shutdown release. A design that counted early undervoltage, or let shutdown restart the ramp, would drop `inhibit`. Finally, a power cycle must reset the retry count: a design that kept the count would latch the fault on the first new trip.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RAMP,
    ST_HOLD,
    ST_DISCH,
    ST_FAULT
  } seq_state_e;

  // Scale a millivolt level onto a code of the given width with a full scale in mV.
  function automatic int mv_to_code(input int mv, input int full_mv, input int width);
    return (mv * ((1 << width) - 1)) / full_mv;
  endfunction

  // True when a retry count plus one new trip reaches the limit.
  function automatic logic retry_hits_limit(input int count, input int limit);
    return (count + 1) >= limit;
  endfunction

  localparam int DEF_SS_W      = 10;
  localparam int DEF_FULL_MV   = 4500;
  localparam int DEF_START_MV  = 1000;
  localparam int DEF_UP_MV     = 4000;
  localparam int DEF_VALLEY_MV = 1200;

endpackage

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen #(
  parameter int SS_W  = 10,
  parameter int DIV_W = 4,
  parameter int START = 227
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic [SS_W-1:0]  level
);
  localparam logic [SS_W-1:0] LVL_MAX   = {SS_W{1'b1}};
  localparam logic [SS_W-1:0] LVL_START = SS_W'(START);

  logic [DIV_W-1:0] dcnt;
  logic             step;

  assign step = run && (dcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      dcnt  <= '0;
    end else if (clr) begin
      level <= '0;
      dcnt  <= '0;
    end else if (load) begin
      level <= LVL_START;
      dcnt  <= '0;
    end else if (run) begin
      if (step) begin
        dcnt <= '0;
        if (level != LVL_MAX) level <= level + 1'b1;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ss_trip_filter.sv
module ss_trip_filter #(
  parameter int N_LIN = 3
) (
  input  logic             armed,
  input  logic             up,
  input  logic             oc,
  input  logic [N_LIN-1:0] luv,
  output logic             trip_evt
);
  logic [N_LIN-1:0] luv_live;

  // Each linear lane is blanked until the ramp is fully charged.
  for (genvar g = 0; g < N_LIN; g++) begin : g_lane
    assign luv_live[g] = luv[g] & up;
  end

  assign trip_evt = armed && (oc || (|luv_live));
endmodule

// File: rtl/ss_fault_keeper.sv
module ss_fault_keeper #(
  parameter int OC_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_done,
  input  logic trip_evt,
  input  logic ov_flag,
  output logic fault_q,
  output logic fault_set,
  output logic ov_q
);
  import ss_seq_pkg::*;

  localparam int CNT_W = $clog2(OC_LIMIT + 1);

  logic [CNT_W-1:0] retry_cnt;
  logic             trip_last;

  assign trip_last = trip_evt && retry_hits_limit(int'(retry_cnt), OC_LIMIT);
  assign fault_set = por_done && !fault_q && (ov_flag || trip_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_cnt <= '0;
      fault_q   <= 1'b0;
      ov_q      <= 1'b0;
    end else if (!por_done) begin
      retry_cnt <= '0;
      fault_q   <= 1'b0;
      ov_q      <= 1'b0;
    end else begin
      if (trip_evt && !fault_q && !trip_last) retry_cnt <= retry_cnt + 1'b1;
      if (fault_set) fault_q <= 1'b1;
      if (ov_flag)   ov_q    <= 1'b1;
    end
  end
endmodule

// File: rtl/ss_fault_seq.sv
module ss_fault_seq #(
  parameter int SS_W      = ss_seq_pkg::DEF_SS_W,
  parameter int DIV_W     = 4,
  parameter int N_LIN     = 3,
  parameter int OC_LIMIT  = 3,
  parameter int FULL_MV   = ss_seq_pkg::DEF_FULL_MV,
  parameter int START_MV  = ss_seq_pkg::DEF_START_MV,
  parameter int UP_MV     = ss_seq_pkg::DEF_UP_MV,
  parameter int VALLEY_MV = ss_seq_pkg::DEF_VALLEY_MV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_done,
  input  logic             shutdown,
  input  logic             oc_flag,
  input  logic             ov_flag,
  input  logic [N_LIN-1:0] luv_flag,
  input  logic [DIV_W-1:0] ramp_div,
  output logic             inhibit,
  output logic             pwm_en,
  output logic             low_force,
  output logic             fault,
  output logic [SS_W-1:0]  ss_level,
  output logic             ss_up
);
  import ss_seq_pkg::*;

  localparam int              START_CODE = mv_to_code(START_MV, FULL_MV, SS_W);
  localparam logic [SS_W-1:0] UP_CODE    = SS_W'(mv_to_code(UP_MV, FULL_MV, SS_W));
  localparam logic [SS_W-1:0] VALLEY_CODE = SS_W'(mv_to_code(VALLEY_MV, FULL_MV, SS_W));

  seq_state_e state, nxt;
  logic       trip_evt, fault_set, fault_q, ov_q;
  logic       ramp_clr, ramp_load, ramp_run, trip_armed;

  assign ss_up      = (ss_level >= UP_CODE);
  assign trip_armed = (state == ST_RAMP) && por_done && !shutdown;

  ss_trip_filter #(.N_LIN(N_LIN)) u_trip (
    .armed    (trip_armed),
    .up       (ss_up),
    .oc       (oc_flag),
    .luv      (luv_flag),
    .trip_evt (trip_evt)
  );

  ss_fault_keeper #(.OC_LIMIT(OC_LIMIT)) u_keep (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_done  (por_done),
    .trip_evt  (trip_evt),
    .ov_flag   (ov_flag),
    .fault_q   (fault_q),
    .fault_set (fault_set),
    .ov_q      (ov_q)
  );

  always_comb begin
    nxt = state;
    if (!por_done)                 nxt = ST_OFF;
    else if (fault_set || fault_q) nxt = ST_FAULT;
    else if (shutdown)             nxt = ST_OFF;
    else begin
      unique case (state)
        ST_OFF:   nxt = ST_RAMP;
        ST_DISCH: nxt = ST_RAMP;
        ST_RAMP:  if (trip_evt) nxt = ss_up ? ST_DISCH : ST_HOLD;
        ST_HOLD:  if (ss_up) nxt = ST_DISCH;
        default:  nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  assign ramp_clr  = (nxt == ST_OFF) || (nxt == ST_DISCH) || (nxt == ST_FAULT);
  assign ramp_load = (nxt == ST_RAMP) && ((state == ST_OFF) || (state == ST_DISCH));
  assign ramp_run  = ((nxt == ST_RAMP) || (nxt == ST_HOLD)) && !ramp_load;

  ss_ramp_gen #(.SS_W(SS_W), .DIV_W(DIV_W), .START(START_CODE)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ramp_clr),
    .load  (ramp_load),
    .run   (ramp_run),
    .div   (ramp_div),
    .level (ss_level)
  );

  assign inhibit   = (state != ST_RAMP);
  assign pwm_en    = (state == ST_RAMP) && (ss_level > VALLEY_CODE);
  assign fault     = fault_q;
  assign low_force = ov_q;
endmodule

// File: rtl/ss_fault_seq_chk.sv
module ss_fault_seq_chk #(
  parameter int SS_W = ss_seq_pkg::DEF_SS_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            por_done,
  input logic            shutdown,
  input logic            oc_flag,
  input logic            ov_flag,
  input logic            inhibit,
  input logic            pwm_en,
  input logic            low_force,
  input logic            fault,
  input logic [SS_W-1:0] ss_level,
  input logic            ss_up,
  input logic            fault_set
);
  import ss_seq_pkg::*;
  localparam logic [SS_W-1:0] VALLEY = SS_W'(mv_to_code(DEF_VALLEY_MV, DEF_FULL_MV, SS_W));

  // R1
  power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |=> (ss_level == '0) && inhibit && !fault && !low_force);

  // R5
  pwm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> (ss_level > VALLEY) && !inhibit);

  // R8
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> inhibit && !pwm_en);

  // R8
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |=> fault && (ss_level == '0));

  // R9
  ov_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && por_done) |=> fault && low_force);

  // R12
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && por_done) |=> fault);

  // R11
  shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (por_done && shutdown) |=> (ss_level == '0) && inhibit);

  // R10
  luv_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (por_done && !inhibit && !ss_up && !oc_flag && !ov_flag && !shutdown) |=> !inhibit);
endmodule

bind ss_fault_seq ss_fault_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por_done  (por_done),
  .shutdown  (shutdown),
  .oc_flag   (oc_flag),
  .ov_flag   (ov_flag),
  .inhibit   (inhibit),
  .pwm_en    (pwm_en),
  .low_force (low_force),
  .fault     (fault),
  .ss_level  (ss_level),
  .ss_up     (ss_up),
  .fault_set (fault_set)
);

// File: tb/test_ss_fault_seq.sv
`timescale 1ns/1ps
module test_ss_fault_seq;
  localparam int START = 227;
  localparam int UPC   = 909;

  // {ramp_div, edges after load, expected level}  (R3)
  localparam int TV [6][3] = '{
    '{0, 10, 237}, '{1, 10, 232}, '{3, 20, 232},
    '{7, 16, 229}, '{2, 7, 229},  '{0, 900, 1023}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic por_done = 1'b0, shutdown = 1'b0, oc_flag = 1'b0, ov_flag = 1'b0;
  logic [2:0] luv_flag = '0;
  logic [3:0] ramp_div = '0;
  logic inhibit, pwm_en, low_force, fault, ss_up;
  logic [9:0] ss_level;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ss_fault_seq i_ss_fault_seq (
    .clk(clk), .rst_n(rst_n), .por_done(por_done), .shutdown(shutdown),
    .oc_flag(oc_flag), .ov_flag(ov_flag), .luv_flag(luv_flag), .ramp_div(ramp_div),
    .inhibit(inhibit), .pwm_en(pwm_en), .low_force(low_force), .fault(fault),
    .ss_level(ss_level), .ss_up(ss_up)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up();
    por_done = 1'b0; tick(2);
    por_done = 1'b1; tick(1);
  endtask

  initial begin
    #(8ns * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(2);
    check("R1 ss", ss_level, 0); check("R1 inhibit", inhibit, 1);
    check("R1 fault", fault, 0); check("R1 pwm_en", pwm_en, 0);
    rst_n = 1'b1; tick(2);
    check("R1 por low ss", ss_level, 0); check("R1 por low inhibit", inhibit, 1);

    for (int i = 0; i < 6; i++) begin
      ramp_div = 4'(TV[i][0]);
      power_up();
      check("R2 load", ss_level, START);
      tick(TV[i][1]);
      check("R3 ramp", ss_level, TV[i][2]);
    end

    ramp_div = '0;
    power_up();
    check("R2 released", inhibit, 0);
    tick(681);
    check("R4 below", ss_up, 0); check("R4 level", ss_level, 908);
    tick(1);
    check("R4 at up", ss_up, 1);
    oc_flag = 1'b1; tick(1); oc_flag = 1'b0;
    check("R6 ss cleared", ss_level, 0); check("R6 inhibit", inhibit, 1);
    tick(1);
    check("R6 reload", ss_level, START); check("R6 release", inhibit, 0);

    oc_flag = 1'b1; tick(1); oc_flag = 1'b0;
    check("R7 inhibit", inhibit, 1); check("R7 still rising", ss_level, START + 1);
    tick(681);
    check("R7 held to up", ss_level, UPC); check("R7 held inhibit", inhibit, 1);
    tick(1);
    check("R7 discharge", ss_level, 0);
    tick(1);
    check("R7 restart", ss_level, START); check("R7 released", inhibit, 0);

    luv_flag = 3'b010; tick(5);
    check("R10 luv blanked", inhibit, 0); check("R10 ramp", ss_level, START + 5);
    check("R10 no fault", fault, 0);
    luv_flag = '0; tick(677);
    check("R10 at up", ss_level, UPC);
    luv_flag = 3'b100; tick(1); luv_flag = '0;
    check("R8 fault", fault, 1); check("R8 inhibit", inhibit, 1);
    check("R8 ss", ss_level, 0); check("R8 no low_force", low_force, 0);
    shutdown = 1'b1; tick(2); shutdown = 1'b0; oc_flag = 1'b1; tick(3); oc_flag = 1'b0;
    check("R8 latch kept", fault, 1); check("R8 no restart", inhibit, 1);
    check("R8 ss stays", ss_level, 0);

    por_done = 1'b0; tick(1);
    check("R12 fault cleared", fault, 0); check("R1 ss off", ss_level, 0);
    por_done = 1'b1; tick(1);
    check("R12 fresh start", ss_level, START);
    tick(45);
    check("R5 at valley", pwm_en, 0);
    tick(1);
    check("R5 above valley", pwm_en, 1);

    shutdown = 1'b1; tick(1);
    check("R11 ss", ss_level, 0); check("R11 inhibit", inhibit, 1); check("R11 pwm", pwm_en, 0);
    tick(3);
    check("R11 stays", ss_level, 0);
    shutdown = 1'b0; tick(1);
    check("R11 restart", ss_level, START);

    oc_flag = 1'b1; tick(1); oc_flag = 1'b0;
    check("R12 count reset", fault, 0); check("R12 trip inhibits", inhibit, 1);

    ov_flag = 1'b1; tick(1); ov_flag = 1'b0;
    check("R9 fault", fault, 1); check("R9 low_force", low_force, 1);
    tick(2);
    check("R9 low_force held", low_force, 1); check("R9 fault held", fault, 1);
    por_done = 1'b0; tick(1);
    check("R12 low_force cleared", low_force, 0); check("R12 fault clear", fault, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule